// File: doc/BRIEF.md
# Set-Associative Cache Tag Model

This block is a tag-only model of a set-associative cache. It works as a statistics engine. It stores no data. It keeps a valid bit, a tag and a recency stamp for every line. Each memory access is classified as one of three outcomes: a hit, a miss that fills an empty way, or a miss that evicts a line. The block keeps one running count for each outcome. The number of set-index bits, the number of ways and the number of block-offset bits are parameters. The default configuration has 256 sets, 4 ways and 4 KiB blocks.

Requests arrive on a valid/ready stream. A request is accepted on a rising clock edge when `req_valid` and `req_ready` are both high. A producer that sees `req_ready` low must hold its request stable and wait. `req_ready` is low only in the cycle after a modify request is accepted. In that cycle the block replays the same address as a store. Every access, including each half of a modify, produces a one-cycle `res_valid` pulse with a result code in the cycle after it is processed. The result has no back-pressure. A consumer must take it in that cycle.

The victim is the least recently used line. Each line carries a stamp from a global access counter. The counter advances once per access. A hit refreshes the stamp of the matching line, and a fill writes the current counter value into the new line.

Top module: `cache_tag_model`

## Requirements
- R1: The address is split into three fields. The low OFS_BITS bits are ignored. The next SET_BITS bits select the set. Every bit above those forms the tag, up to and including bit 63.
- R2: An access whose tag equals the tag of a valid way in the selected set is a hit. It reports result code 2'b01.
- R3: A miss in a set that still has an invalid way fills the lowest-numbered invalid way. It reports code 2'b10 and increments only the miss counter.
- R4: A miss in a full set replaces the way with the smallest recency stamp. It reports code 2'b11 and increments both the miss counter and the eviction counter. The eviction count never exceeds the miss count.
- R5: Every access writes the current value of the global stamp counter into the line it touches. A line that was hit recently therefore outlives lines that were filled before that hit.
- R6: Operation codes are 2'b00 load, 2'b01 store, 2'b10 modify and 2'b11 (treated as a load). A modify is accepted once and produces two results: first the load outcome, then the store outcome. The store outcome is always a hit. `req_ready` is low for exactly the one cycle between the two halves.
- R7: The result of an access accepted at a clock edge appears with `res_valid` high in the following cycle, with a nonzero code. `res_valid` is low in any cycle with no access.
- R8: `hit_count`, `miss_count` and `evict_count` rise by one for each matching result and hold in every other cycle.
- R9: Reset clears every valid bit, the stamp counter and the three counters. The first access to any address after reset misses.
- R10: Sets are independent. The same tag in a different set occupies a separate line and misses on its first use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W (64) | Byte address of the access |
| req_op | input | 2 | Operation code (see R6) |
| res_valid | output | 1 | One-cycle pulse per processed access |
| res_kind | output | 2 | 01 hit, 10 miss, 11 miss with eviction |
| hit_count | output | CNT_W (32) | Running count of hits |
| miss_count | output | CNT_W (32) | Running count of misses |
| evict_count | output | CNT_W (32) | Running count of evictions |

## Verification
The bench fills a set with four tags. It then refreshes the oldest tag and forces evictions. A design that used fill order instead of access recency would evict the refreshed line and report a miss where a hit is expected. An offset-only change of address must still hit, and a change in bit 63 alone must miss. These two checks catch a field split that is too narrow or that lets offset bits leak into the tag. Modify requests are checked for their two results and for the single low-ready cycle between them. A design that skipped the replayed store, or kept ready low for too long, would miscount hits or stall the stream. A reset in the middle of the run must make a previously resident line miss again and must bring all three counters back to zero.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_MODIFY = 2'b10,
    OP_SPARE  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'b00,
    RES_HIT   = 2'b01,
    RES_MISS  = 2'b10,
    RES_EVICT = 2'b11
  } res_e;

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
  parameter int ADDR_W   = 64,
  parameter int OFS_BITS = 12,
  parameter int SET_BITS = 8,
  parameter int TAG_W    = ADDR_W - OFS_BITS - SET_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [SET_BITS-1:0] set_idx,
  output logic [TAG_W-1:0]    tag
);

  // Offset bits select a byte inside the block; the model ignores them (R1).
  logic unused_offset;
  assign unused_offset = ^addr[OFS_BITS-1:0];

  assign set_idx = addr[OFS_BITS +: SET_BITS];
  assign tag     = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 44,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]       line_valid,
  input  logic [WAYS*TAG_W-1:0] line_tags,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);

  logic [WAYS-1:0] match;

  // One comparator per way, all in parallel (R2).
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = line_valid[w] && (line_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
  parameter int WAYS    = 4,
  parameter int STAMP_W = 32,
  parameter int WAY_W   = 2
) (
  input  logic [WAYS-1:0]         line_valid,
  input  logic [WAYS*STAMP_W-1:0] line_stamps,
  output logic                    set_full,
  output logic [WAY_W-1:0]        victim
);

  logic               found;
  logic [STAMP_W-1:0] best;

  assign set_full = &line_valid;

  always_comb begin
    victim = '0;
    found  = 1'b0;
    best   = line_stamps[0 +: STAMP_W];
    if (!set_full) begin
      // Lowest-numbered empty way first (R3).
      for (int w = 0; w < WAYS; w++) begin
        if (!found && !line_valid[w]) begin
          victim = WAY_W'(w);
          found  = 1'b1;
        end
      end
    end else begin
      // Oldest stamp loses (R4); stamps are unique so strict compare suffices.
      for (int w = 1; w < WAYS; w++) begin
        if (line_stamps[w*STAMP_W +: STAMP_W] < best) begin
          best   = line_stamps[w*STAMP_W +: STAMP_W];
          victim = WAY_W'(w);
        end
      end
    end
  end

endmodule

// File: rtl/cache_tag_model.sv
module cache_tag_model
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int OFS_BITS = 12,
  parameter int SET_BITS = 8,
  parameter int WAYS     = 4,
  parameter int STAMP_W  = 32,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count,
  output logic [CNT_W-1:0]  evict_count
);

  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - OFS_BITS - SET_BITS;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Line state
  logic [WAYS-1:0]    valid_q [SETS];
  logic [TAG_W-1:0]   tag_q   [SETS][WAYS];
  logic [STAMP_W-1:0] stamp_q [SETS][WAYS];
  logic [STAMP_W-1:0] now_q;

  // Second half of a modify pending
  logic              busy_q;
  logic [ADDR_W-1:0] hold_addr_q;

  logic              acc_fire;
  logic [ADDR_W-1:0] acc_addr;
  logic [SET_BITS-1:0] set_idx;
  logic [TAG_W-1:0]  look_tag;

  logic [WAYS-1:0]         row_valid;
  logic [WAYS*TAG_W-1:0]   row_tags;
  logic [WAYS*STAMP_W-1:0] row_stamps;

  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic             set_full;
  logic [WAY_W-1:0] victim;
  logic [WAY_W-1:0] touch_way;
  res_e             outcome;

  assign req_ready = !busy_q;
  assign acc_fire  = busy_q || req_valid;
  assign acc_addr  = busy_q ? hold_addr_q : req_addr;

  cache_addr_split #(
    .ADDR_W  (ADDR_W),
    .OFS_BITS(OFS_BITS),
    .SET_BITS(SET_BITS),
    .TAG_W   (TAG_W)
  ) u_split (
    .addr   (acc_addr),
    .set_idx(set_idx),
    .tag    (look_tag)
  );

  always_comb begin
    row_valid = valid_q[set_idx];
    for (int w = 0; w < WAYS; w++) begin
      row_tags[w*TAG_W +: TAG_W]       = tag_q[set_idx][w];
      row_stamps[w*STAMP_W +: STAMP_W] = stamp_q[set_idx][w];
    end
  end

  cache_way_match #(
    .WAYS (WAYS),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_match (
    .line_valid(row_valid),
    .line_tags (row_tags),
    .look_tag  (look_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  cache_victim_pick #(
    .WAYS   (WAYS),
    .STAMP_W(STAMP_W),
    .WAY_W  (WAY_W)
  ) u_victim (
    .line_valid (row_valid),
    .line_stamps(row_stamps),
    .set_full   (set_full),
    .victim     (victim)
  );

  assign touch_way = hit ? hit_way : victim;

  always_comb begin
    if (hit)           outcome = RES_HIT;
    else if (set_full) outcome = RES_EVICT;
    else               outcome = RES_MISS;
  end

  // Control, valid bits and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      now_q       <= '0;
      busy_q      <= 1'b0;
      hold_addr_q <= '0;
      res_valid   <= 1'b0;
      res_kind    <= RES_NONE;
      hit_count   <= '0;
      miss_count  <= '0;
      evict_count <= '0;
    end else begin
      res_valid <= acc_fire;
      res_kind  <= acc_fire ? outcome : RES_NONE;
      busy_q    <= !busy_q && req_valid && (op_e'(req_op) == OP_MODIFY);
      if (!busy_q && req_valid) hold_addr_q <= req_addr;
      if (acc_fire) begin
        now_q <= now_q + 1'b1;
        valid_q[set_idx][touch_way] <= 1'b1;
        case (outcome)
          RES_HIT:   hit_count  <= hit_count + 1'b1;
          RES_MISS:  miss_count <= miss_count + 1'b1;
          RES_EVICT: begin
            miss_count  <= miss_count + 1'b1;
            evict_count <= evict_count + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Tag and recency storage; meaningful only where valid is set
  always_ff @(posedge clk) begin
    if (acc_fire) begin
      tag_q[set_idx][touch_way]   <= look_tag;
      stamp_q[set_idx][touch_way] <= now_q;
    end
  end

endmodule

// File: rtl/cache_tag_model_chk.sv
module cache_tag_model_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic             res_valid,
  input logic [1:0]       res_kind,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] evict_count
);

  logic take_modify;
  assign take_modify = req_valid && req_ready && (req_op == 2'b10);

  p_modify_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_modify |=> !req_ready);

  p_modify_tail_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_modify |-> ##2 (res_valid && res_kind == 2'b01));

  p_ready_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> req_ready);

  p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  p_code_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_kind != 2'b00));

  p_hit_counted_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'b01) |->
      (hit_count == CNT_W'($past(hit_count) + 1'b1)) && $stable(miss_count) && $stable(evict_count));

  p_miss_counted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'b10) |->
      (miss_count == CNT_W'($past(miss_count) + 1'b1)) && $stable(evict_count) && $stable(hit_count));

  p_evict_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 2'b11) |->
      (miss_count == CNT_W'($past(miss_count) + 1'b1)) &&
      (evict_count == CNT_W'($past(evict_count) + 1'b1)));

  p_evict_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evict_count <= miss_count);

  p_counts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(hit_count) && $stable(miss_count) && $stable(evict_count)));

endmodule

bind cache_tag_model cache_tag_model_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .res_valid  (res_valid),
  .res_kind   (res_kind),
  .hit_count  (hit_count),
  .miss_count (miss_count),
  .evict_count(evict_count)
);

// File: tb/cache_tag_model_bench.sv
`timescale 1ns/1ps
module cache_tag_model_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_op = 2'b00;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [31:0] hit_count, miss_count, evict_count;

  int checks = 0;
  int errors = 0;
  int eh = 0, em = 0, ee = 0;

  always #4 clk = ~clk;

  cache_tag_model u_cache_tag_model (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op),
    .res_valid(res_valid), .res_kind(res_kind),
    .hit_count(hit_count), .miss_count(miss_count), .evict_count(evict_count)
  );

  // {op, tag, set, offset, expected first code}: 2+8+8+12+2 bits
  localparam int NV = 15;
  localparam logic [31:0] VECS [NV] = '{
    {2'd0, 8'd1, 8'd5, 12'h000, 2'd2},  // cold fill
    {2'd0, 8'd1, 8'd5, 12'hABC, 2'd1},  // R1: offset change only, hit
    {2'd1, 8'd2, 8'd5, 12'h010, 2'd2},
    {2'd0, 8'd3, 8'd5, 12'h000, 2'd2},
    {2'd0, 8'd4, 8'd5, 12'hFFF, 2'd2},  // R3: fourth fill, still no eviction
    {2'd0, 8'd1, 8'd5, 12'h000, 2'd1},  // refresh tag 1
    {2'd0, 8'd5, 8'd5, 12'h000, 2'd3},  // evicts tag 2
    {2'd0, 8'd2, 8'd5, 12'h000, 2'd3},  // evicts tag 3
    {2'd0, 8'd1, 8'd5, 12'h000, 2'd1},  // R5: refreshed line survived
    {2'd0, 8'd3, 8'd5, 12'h000, 2'd3},  // evicts tag 4
    {2'd0, 8'd1, 8'd6, 12'h000, 2'd2},  // R10: same tag, other set
    {2'd2, 8'd7, 8'd9, 12'h000, 2'd2},  // R6: modify, miss then hit
    {2'd2, 8'd7, 8'd9, 12'h040, 2'd1},  // R6: modify, hit then hit
    {2'd0, 8'd1, 8'd6, 12'h000, 2'd1},
    {2'd3, 8'd7, 8'd9, 12'h000, 2'd1}   // spare code acts as load
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic string kind_req(input logic [1:0] k);
    case (k)
      2'd1:    return "R2 hit code";
      2'd2:    return "R3 miss code";
      default: return "R4 evict code";
    endcase
  endfunction

  task automatic tally(input logic [1:0] k);
    if (k == 2'd1) eh++;
    else begin
      em++;
      if (k == 2'd3) ee++;
    end
  endtask

  task automatic check_counts();
    chk(hit_count == 32'(eh),   "R8 hit_count",   hit_count,   eh);
    chk(miss_count == 32'(em),  "R8 miss_count",  miss_count,  em);
    chk(evict_count == 32'(ee), "R8 evict_count", evict_count, ee);
  endtask

  task automatic do_access(input logic [1:0] op, input logic [63:0] addr, input logic [1:0] exp1);
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = addr;
    req_op    = op;
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b1, "R7 result pulse", res_valid, 1);
    chk(res_kind == exp1, kind_req(exp1), res_kind, exp1);
    tally(exp1);
    if (op == 2'd2) begin
      chk(req_ready == 1'b0, "R6 ready low between halves", req_ready, 0);
      @(negedge clk);
      chk(res_valid == 1'b1, "R6 second result", res_valid, 1);
      chk(res_kind == 2'd1, "R6 store half hits", res_kind, 1);
      tally(2'd1);
    end
    check_counts();
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 idle no result", res_valid, 0);
    chk(req_ready == 1'b1, "R6 ready restored", req_ready, 1);
    check_counts();
  endtask

  function automatic logic [63:0] mk_addr(input logic [7:0] tag, input logic [7:0] set, input logic [11:0] ofs);
    return {36'd0, tag, set, ofs};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_valid == 1'b0, "R9 res_valid in reset", res_valid, 0);
    check_counts();
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R7 no result without request", res_valid, 0);

    for (int i = 0; i < NV; i++) begin
      do_access(VECS[i][31:30], mk_addr(VECS[i][29:22], VECS[i][21:14], VECS[i][13:2]), VECS[i][1:0]);
    end

    // R1: bit 63 is tag; set 5 is full, oldest resident (tag 5) is replaced
    do_access(2'd0, {1'b1, 35'd0, 8'd1, 8'd5, 12'h000}, 2'd3);
    // R1: original tag 1 still resident alongside the new line
    do_access(2'd0, mk_addr(8'd1, 8'd5, 12'h000), 2'd1);

    // R9: reset mid-run clears lines and counters
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    eh = 0; em = 0; ee = 0;
    @(negedge clk);
    chk(hit_count == 0,   "R9 hit_count cleared",   hit_count,   0);
    chk(miss_count == 0,  "R9 miss_count cleared",  miss_count,  0);
    chk(evict_count == 0, "R9 evict_count cleared", evict_count, 0);
    do_access(2'd0, mk_addr(8'd1, 8'd6, 12'h000), 2'd2);  // R9: was resident, now misses

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule